// File: doc/BRIEF.md
# Circuit-Switched Mesh Node Router

This block is one node of a two-dimensional mesh in which transfers travel over reserved paths. It has four neighbour ports (west, east, north, south) and one local client port, and each port has an input side and an output side. A burst begins with a header word that carries the destination coordinates. The node routes that header dimension-ordered: it resolves the horizontal offset first and the vertical offset second. When several headers compete for one output, a fixed priority picks the winner. The winning input keeps the output until the word flagged as tail has passed. Every word after the header follows the same path, so the header sets up the circuit hop by hop.

Each input has a one-word register. A header that cannot get its output waits in that register and retries every cycle, and the port's ready signal stays low while it waits. Downstream readiness passes straight back to the source that owns the output. For each header the node reports how many cycles it spent in the input register before its grant. A testbench can average these counts to measure the connection establishing time under different burst lengths and gaps between bursts.

Top module: `mesh_node_router`

## Requirements
- R1: After reset every output valid is low and every input ready is high.
- R2: A header's destination x is held in data bits [CW-1:0]. When it is above the node's x the header leaves by east (port index 1). When it is below, the header leaves by west (index 0).
- R3: The destination y is held in data bits [2*CW-1:CW]. When x matches the node, a larger y leaves by north (index 2) and a smaller y by south (index 3). When both match, the header leaves by the local port (index 4).
- R4: When headers from several inputs want the same free output, the lowest port index wins. The order is therefore west, east, north, south, then local.
- R5: A header that loses arbitration stays in its input register with that input's ready low, and it retries every cycle until it is granted.
- R6: Once granted, an output carries only the words of the owning input, in order, from the header up to and including the tail word.
- R7: The cycle after a tail word is transferred, the output is free, and a waiting header is granted in that cycle.
- R8: While an output is valid and its ready is low, the word on that output stays unchanged and the owning input cannot accept new data.
- R9: Circuits through different outputs run at the same time and do not affect each other.
- R10: In the cycle an input's header is granted, setup_done for that input pulses. setup_cycles then gives the number of cycles the header spent in the register, counting the grant cycle, so an immediate grant reads 1.
- R11: A header that also carries the tail flag sets up and releases its output with a single transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | NPORT | Word offered on each input |
| in_tail | input | NPORT | Offered word is the last of its burst |
| in_data | input | NPORT*DW | Offered words, input i at bits [i*DW +: DW] |
| in_rdy | output | NPORT | Input register can take a word this cycle |
| out_vld | output | NPORT | Word presented on each output |
| out_tail | output | NPORT | Presented word is the last of its burst |
| out_data | output | NPORT*DW | Presented words, output o at bits [o*DW +: DW] |
| out_rdy | input | NPORT | Receiver takes the presented word this cycle |
| setup_done | output | NPORT | Header of input i granted this cycle |
| setup_cycles | output | NPORT*CNTW | Setup latency of the granted header of input i |

## Verification
The bound checker watches every cycle for four things. No input ever owns two outputs. An output stays locked to the same owner until its tail word transfers, and it is free right after that. A waiting word or a stalled output word does not change. A reported setup count is never zero. Only the bench's scenarios can show the rest: that routing sends each destination to the correct port, that the priority order decides which header wins, and that the exact latency counts match the cycles waited. The bench also shows that two circuits to different outputs really run side by side.

// File: rtl/mesh_node_pkg.sv
// Shared constants and port numbering for the mesh node router.
// Assumes five ports per node: four neighbours plus one local client.
package mesh_node_pkg;
    localparam int NPORT = 5;
    localparam int PW    = 3;   // bits needed for a port index

    typedef enum logic [PW-1:0] {
        PORT_WEST  = 3'd0,
        PORT_EAST  = 3'd1,
        PORT_NORTH = 3'd2,
        PORT_SOUTH = 3'd3,
        PORT_LOCAL = 3'd4
    } port_e;
endpackage

// File: rtl/mesh_in_reg.sv
// One-word input register for a node port.
// Holds a word until the switch takes it; take may arrive in the same
// cycle as a new word, so a continuous stream passes at one word per cycle.
module mesh_in_reg #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic          in_tail,
    input  logic [DW-1:0] in_data,
    input  logic          take,
    output logic          in_rdy,
    output logic          reg_vld,
    output logic          reg_tail,
    output logic [DW-1:0] reg_data
);
    // Ready when empty or when the held word leaves this cycle.
    assign in_rdy = !reg_vld || take;

    // Capture a new word whenever the slot is (or becomes) free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_vld  <= 1'b0;
            reg_tail <= 1'b0;
            reg_data <= '0;
        end else if (in_rdy) begin
            reg_vld <= in_vld;
            if (in_vld) begin
                reg_tail <= in_tail;
                reg_data <= in_data;
            end
        end
    end
endmodule

// File: rtl/mesh_route.sv
// Dimension-ordered route computation for a header word.
// Resolves x before y; the header carries x in the low CW bits
// and y in the next CW bits. Purely combinational.
module mesh_route
    import mesh_node_pkg::*;
#(
    parameter int CW   = 3,
    parameter int MY_X = 2,
    parameter int MY_Y = 2
) (
    input  logic [2*CW-1:0] hdr,
    output logic [PW-1:0]   dir
);
    logic [CW-1:0] dst_x, dst_y;
    assign dst_x = hdr[CW-1:0];
    assign dst_y = hdr[2*CW-1:CW];

    // Choose the output port: horizontal offset first, then vertical.
    always_comb begin
        if (dst_x > CW'(MY_X))      dir = PORT_EAST;
        else if (dst_x < CW'(MY_X)) dir = PORT_WEST;
        else if (dst_y > CW'(MY_Y)) dir = PORT_NORTH;
        else if (dst_y < CW'(MY_Y)) dir = PORT_SOUTH;
        else                        dir = PORT_LOCAL;
    end
endmodule

// File: rtl/mesh_out_arb.sv
// Fixed-priority arbiter and circuit lock for one output port.
// The lowest requesting input index wins a free output. The winner keeps
// it until a tail word transfers; the output is free the following cycle.
module mesh_out_arb #(
    parameter int NPORT = 5,
    parameter int PW    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] req,
    input  logic             tail_xfer,
    output logic             lock_v,
    output logic [PW-1:0]    lock_own,
    output logic [NPORT-1:0] grant,
    output logic             sel_v,
    output logic [PW-1:0]    sel_idx
);
    logic          pick_v;
    logic [PW-1:0] pick_idx;

    // Priority pick: scanning downward leaves the lowest index set.
    always_comb begin
        pick_v   = 1'b0;
        pick_idx = '0;
        for (int i = NPORT - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick_v   = 1'b1;
                pick_idx = PW'(i);
            end
        end
    end

    // One-hot grant only while the output is free.
    always_comb begin
        grant = '0;
        for (int i = 0; i < NPORT; i++) begin
            if (!lock_v && pick_v && pick_idx == PW'(i)) grant[i] = 1'b1;
        end
    end

    // Switch select: the locked owner, or this cycle's winner.
    assign sel_v   = lock_v || pick_v;
    assign sel_idx = lock_v ? lock_own : pick_idx;

    // Lock state: set on grant, cleared by a transferred tail word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_v   <= 1'b0;
            lock_own <= '0;
        end else if (tail_xfer) begin
            lock_v   <= 1'b0;
        end else if (!lock_v && pick_v) begin
            lock_v   <= 1'b1;
            lock_own <= pick_idx;
        end
    end
endmodule

// File: rtl/mesh_setup_timer.sv
// Per-input connection setup latency counter.
// Counts the cycles a header waits in its register; on grant it reports
// the wait plus the grant cycle. Saturates instead of wrapping.
module mesh_setup_timer #(
    parameter int CNTW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            waiting,
    input  logic            granted,
    output logic            setup_done,
    output logic [CNTW-1:0] setup_cycles
);
    localparam logic [CNTW-1:0] CNT_CAP = {{(CNTW-1){1'b1}}, 1'b0};

    logic [CNTW-1:0] wait_cnt;

    assign setup_done   = granted;
    assign setup_cycles = wait_cnt + 1'b1;

    // Accumulate lost cycles; clear once the header is granted or absent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_cnt <= '0;
        end else if (waiting && !granted) begin
            if (wait_cnt < CNT_CAP) wait_cnt <= wait_cnt + 1'b1;
        end else begin
            wait_cnt <= '0;
        end
    end
endmodule

// File: rtl/mesh_node_router.sv
// Circuit-switched node for a 2D mesh: input registers, route logic,
// per-output fixed-priority arbiters and the crossbar switch.
// A word in an input register that owns no output is a header. Ready flows
// combinationally from an output back to the input that owns it.
// Assumes DW >= 2*CW and that headers never route back out of their own port.
module mesh_node_router
    import mesh_node_pkg::*;
#(
    parameter int DW   = 16,
    parameter int CW   = 3,
    parameter int MY_X = 2,
    parameter int MY_Y = 2,
    parameter int CNTW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPORT-1:0]      in_vld,
    input  logic [NPORT-1:0]      in_tail,
    input  logic [NPORT*DW-1:0]   in_data,
    output logic [NPORT-1:0]      in_rdy,
    output logic [NPORT-1:0]      out_vld,
    output logic [NPORT-1:0]      out_tail,
    output logic [NPORT*DW-1:0]   out_data,
    input  logic [NPORT-1:0]      out_rdy,
    output logic [NPORT-1:0]      setup_done,
    output logic [NPORT*CNTW-1:0] setup_cycles
);
    logic [NPORT-1:0]                reg_vld, reg_tail, take;
    logic [NPORT-1:0]                hdr_req, connected, granted_now;
    logic [NPORT-1:0][DW-1:0]        reg_data;
    logic [NPORT-1:0][PW-1:0]        dir;
    logic [NPORT-1:0]                lock_v, sel_v, tail_xfer;
    logic [NPORT-1:0][PW-1:0]        lock_own, sel_idx;
    logic [NPORT-1:0][NPORT-1:0]     req_m, grant_m;   // [output][input]

    // Per-input datapath: register, route and setup timer.
    for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
        mesh_in_reg #(.DW(DW)) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_vld   (in_vld[gi]),
            .in_tail  (in_tail[gi]),
            .in_data  (in_data[gi*DW +: DW]),
            .take     (take[gi]),
            .in_rdy   (in_rdy[gi]),
            .reg_vld  (reg_vld[gi]),
            .reg_tail (reg_tail[gi]),
            .reg_data (reg_data[gi])
        );

        mesh_route #(.CW(CW), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
            .hdr (reg_data[gi][2*CW-1:0]),
            .dir (dir[gi])
        );

        mesh_setup_timer #(.CNTW(CNTW)) u_timer (
            .clk          (clk),
            .rst_n        (rst_n),
            .waiting      (hdr_req[gi]),
            .granted      (granted_now[gi]),
            .setup_done   (setup_done[gi]),
            .setup_cycles (setup_cycles[gi*CNTW +: CNTW])
        );
    end

    // Inputs already owning an output carry burst data, not headers.
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            connected[i] = 1'b0;
            for (int o = 0; o < NPORT; o++) begin
                if (lock_v[o] && lock_own[o] == PW'(i)) connected[i] = 1'b1;
            end
            hdr_req[i] = reg_vld[i] && !connected[i];
        end
    end

    // Request matrix: each waiting header asks for its routed output.
    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                req_m[o][i] = hdr_req[i] && (dir[i] == PW'(o));
            end
        end
    end

    // Per-output arbitration and circuit hold.
    for (genvar go = 0; go < NPORT; go++) begin : g_out
        mesh_out_arb #(.NPORT(NPORT), .PW(PW)) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (req_m[go]),
            .tail_xfer (tail_xfer[go]),
            .lock_v    (lock_v[go]),
            .lock_own  (lock_own[go]),
            .grant     (grant_m[go]),
            .sel_v     (sel_v[go]),
            .sel_idx   (sel_idx[go])
        );
    end

    // Crossbar: steer the selected input register onto each output.
    always_comb begin
        out_vld  = '0;
        out_tail = '0;
        out_data = '0;
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                if (sel_v[o] && sel_idx[o] == PW'(i)) begin
                    out_vld[o]            = reg_vld[i];
                    out_tail[o]           = reg_tail[i];
                    out_data[o*DW +: DW]  = reg_data[i];
                end
            end
            tail_xfer[o] = out_vld[o] && out_tail[o] && out_rdy[o];
        end
    end

    // Backward path: a word leaves its input when its output is ready.
    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            take[i]        = 1'b0;
            granted_now[i] = 1'b0;
            for (int o = 0; o < NPORT; o++) begin
                if (sel_v[o] && sel_idx[o] == PW'(i) && out_rdy[o]) take[i] = 1'b1;
                if (grant_m[o][i]) granted_now[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mesh_node_router_chk.sv
// Property checker for the mesh node router, attached by bind.
// Observes ports plus the lock and input register state.
module mesh_node_router_chk
    import mesh_node_pkg::*;
#(
    parameter int DW   = 16,
    parameter int CNTW = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NPORT-1:0]         in_rdy,
    input logic [NPORT-1:0]         out_vld,
    input logic [NPORT-1:0]         out_tail,
    input logic [NPORT*DW-1:0]      out_data,
    input logic [NPORT-1:0]         out_rdy,
    input logic [NPORT-1:0]         setup_done,
    input logic [NPORT*CNTW-1:0]    setup_cycles,
    input logic [NPORT-1:0]         lock_v,
    input logic [NPORT-1:0][PW-1:0] lock_own,
    input logic [NPORT-1:0]         reg_vld,
    input logic [NPORT-1:0][DW-1:0] reg_data
);
    logic [NPORT-1:0][NPORT-1:0] own_m;   // [input][output]

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            for (int o = 0; o < NPORT; o++) begin
                own_m[i][o] = lock_v[o] && lock_own[o] == PW'(i);
            end
        end
    end

    for (genvar g = 0; g < NPORT; g++) begin : g_chk
        assert_one_circuit_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(own_m[g]) <= 1);

        assert_lock_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
            lock_v[g] && !(out_vld[g] && out_tail[g] && out_rdy[g])
            |=> lock_v[g] && $stable(lock_own[g]));

        assert_tail_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld[g] && out_tail[g] && out_rdy[g] |=> !lock_v[g]);

        assert_stall_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
            out_vld[g] && !out_rdy[g]
            |=> out_vld[g] && $stable(out_data[g*DW +: DW]));

        assert_waiting_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
            reg_vld[g] && !in_rdy[g] |=> reg_vld[g] && $stable(reg_data[g]));

        assert_setup_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
            setup_done[g] |-> setup_cycles[g*CNTW +: CNTW] != '0);
    end
endmodule

bind mesh_node_router mesh_node_router_chk #(.DW(DW), .CNTW(CNTW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_rdy       (in_rdy),
    .out_vld      (out_vld),
    .out_tail     (out_tail),
    .out_data     (out_data),
    .out_rdy      (out_rdy),
    .setup_done   (setup_done),
    .setup_cycles (setup_cycles),
    .lock_v       (lock_v),
    .lock_own     (lock_own),
    .reg_vld      (reg_vld),
    .reg_data     (reg_data)
);

// File: tb/tb_mesh_node_router.sv
// Self-checking bench: directed arbitration, stall and release cases plus
// seeded random single-word bursts checked against a bench route function.
module tb_mesh_node_router;
    localparam int DW = 8, CW = 2, MX = 1, MY = 1, CNTW = 6, NP = 5;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NP-1:0] in_vld = '0, in_tail = '0, in_rdy, out_vld, out_tail, out_rdy = '1, setup_done;
    logic [NP*DW-1:0] in_data = '0, out_data;
    logic [NP*CNTW-1:0] setup_cycles;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mesh_node_router #(.DW(DW), .CW(CW), .MY_X(MX), .MY_Y(MY), .CNTW(CNTW)) dut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_tail(in_tail), .in_data(in_data),
        .in_rdy(in_rdy), .out_vld(out_vld), .out_tail(out_tail), .out_data(out_data),
        .out_rdy(out_rdy), .setup_done(setup_done), .setup_cycles(setup_cycles));

    function automatic int route_of(int x, int y);
        if (x > MX) return 1;
        if (x < MX) return 0;
        if (y > MY) return 2;
        if (y < MY) return 3;
        return 4;
    endfunction

    function automatic logic [DW-1:0] hdr(int tag, int x, int y);
        return {4'(tag), 2'(y), 2'(x)};
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(int p, bit v, bit t, logic [DW-1:0] d);
        in_vld[p] = v;
        in_tail[p] = t;
        in_data[p*DW +: DW] = d;
    endtask

    function automatic int odata(int o);
        return int'(out_data[o*DW +: DW]);
    endfunction

    function automatic int scyc(int i);
        return int'(setup_cycles[i*CNTW +: CNTW]);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_vld", out_vld, 0);
        check("R1 in_rdy", in_rdy, 5'h1f);

        // Priority: W (0), N (2) and L (4) all head east at once.
        drive(0, 1, 0, hdr(1, 3, 1));
        drive(2, 1, 1, hdr(2, 3, 1));
        drive(4, 1, 1, hdr(3, 3, 1));
        @(negedge clk);
        check("R4 east vld", out_vld[1], 1);
        check("R4 west wins", odata(1), hdr(1, 3, 1));
        check("R10 immediate done", setup_done[0], 1);
        check("R10 immediate count", scyc(0), 1);
        check("R5 loser stalled", in_rdy[2], 0);
        drive(2, 0, 0, 0);
        drive(4, 0, 0, 0);
        drive(0, 1, 1, 8'hA5);
        @(negedge clk);
        check("R6 tail follows header", odata(1), 8'hA5);
        check("R6 tail flag", out_tail[1], 1);
        check("R5 still waiting", in_rdy[2], 0);
        drive(0, 0, 0, 0);
        @(negedge clk);
        check("R7 next winner north", odata(1), hdr(2, 3, 1));
        check("R7 grant after release", setup_done[2], 1);
        check("R10 waited count", scyc(2), 3);
        @(negedge clk);
        check("R11 single-word release", odata(1), hdr(3, 3, 1));
        check("R10 local count", scyc(4), 4);
        @(negedge clk);
        check("R11 idle after", out_vld, 0);

        // Stall and parallel circuits.
        out_rdy[1] = 1'b0;
        drive(0, 1, 0, hdr(5, 2, 0));
        @(negedge clk);
        check("R8 stalled word shown", odata(1), hdr(5, 2, 0));
        check("R8 source blocked", in_rdy[0], 0);
        drive(0, 0, 0, 0);
        drive(3, 1, 1, hdr(6, 1, 1));
        @(negedge clk);
        check("R9 local circuit", out_vld[4], 1);
        check("R9 local data", odata(4), hdr(6, 1, 1));
        check("R8 word held", odata(1), hdr(5, 2, 0));
        check("R8 vld held", out_vld[1], 1);
        drive(3, 0, 0, 0);
        out_rdy[1] = 1'b1;
        drive(0, 1, 1, 8'h3C);
        @(negedge clk);
        check("R6 tail after stall", odata(1), 8'h3C);
        check("R9 local done", out_vld[4], 0);
        drive(0, 0, 0, 0);
        @(negedge clk);
        check("R7 idle after stall", out_vld, 0);

        // Random single-word bursts from random inputs to random nodes.
        for (int k = 0; k < 40; k++) begin
            int p = $urandom_range(0, 4);
            int x = $urandom_range(0, 3);
            int y = $urandom_range(0, 3);
            int o = route_of(x, y);
            string rq = (x == MX) ? "R3" : "R2";
            drive(p, 1, 1, hdr(k % 16, x, y));
            @(negedge clk);
            check({rq, " route vld"}, out_vld[o], 1);
            check({rq, " route data"}, odata(o), hdr(k % 16, x, y));
            check("R10 random count", scyc(p), 1);
            drive(p, 0, 0, 0);
            @(negedge clk);
            check("R11 random release", out_vld, 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule